// File: doc/BRIEF.md
# Vector-Routing Interrupt Controller

This block gathers 64 interrupt inputs and forwards their state changes to a single downstream interrupt controller. Each line holds a mask bit, a trigger-mode bit (edge or level), a message-enable bit, a request bit and an in-service bit. An 8-bit vector table gives each line the number under which the downstream controller sees it. When a line starts being serviced, the block emits an assert event carrying that line's vector. When it stops being serviced, the block emits a deassert event with the same vector.

Software reaches the block over a 32-bit register bus. Each 64-bit state register appears as two 32-bit words, and address bit 2 selects the upper word. Edge requests stay latched until software writes ones to a clear window. Changing a mask bit re-evaluates the affected lines. Events leave one per accepted handshake on a valid/ready port, lowest-numbered line first.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every mask bit is 1. Every edge-mode, message-enable and vector entry reads 0, and `evt_valid` is low.
- R2: Mask (byte offset 0x20), message enable (0x40) and edge mode (0x60, 1 = edge) are 64-bit registers. Address bit 2 selects bits 63:32, the other 32 bits select bits 31:0, and a write to one half leaves the other half unchanged.
- R3: The identification window (0x00) reads 0x07000000 at 0x00. At 0x04 it reads 0x001F0001: version 1 in bits 15:0 and the value 31 in bits 31:16.
- R4: The two control windows (0xC0, 0xE0) and the polarity window (0x3E0) always read 0, and writes to them are ignored. Route bytes (0x100+line) always read 1. Vector bytes (0x200+line) store bits 7:0 of the write data and read them back in bits 7:0.
- R5: `bus_err` is raised in the same cycle as the request for an offset outside every window, for a write to the identification window, and for a read of the clear window (0x80). An erroring read returns 0.
- R6: A rising input on an unmasked line sets its request and in-service state and sends an assert event (`evt_level` = 1) with the line's vector. A falling input on a level line clears the request and sends a deassert event (`evt_level` = 0).
- R7: On an edge line a falling input never clears the request, and no event follows it.
- R8: A write to the clear window (0x80/0x84) clears a line's request only where the data bit is 1, the line is in edge mode and the request is set; each such line then sends a deassert event. A rising input in the same cycle as the clear keeps the request set and sends an assert event.
- R9: Changing a mask bit from 1 to 0 while the line's request is set sends an assert event. Setting a mask bit does not retract an asserted line; its deassert still follows the request.
- R10: When several events are outstanding they leave lowest line first, one per cycle with `evt_valid` and `evt_ready` both high. `evt_valid` stays high while `evt_ready` is low.
- R11: A line holds at most one outstanding event. If its state changes again before delivery, the single event carries the line's current in-service level.
- R12: A masked line records a rising input as a request but sets no in-service bit and sends no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 64 | Interrupt inputs, one per line |
| bus_req | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| bus_err | output | 1 | Bad access, same cycle |
| evt_valid | output | 1 | Downstream event available |
| evt_ready | input | 1 | Downstream accepts the event |
| evt_vec | output | 8 | Vector of the event's line |
| evt_level | output | 1 | 1 = assert, 0 = deassert |

## Verification
Two functions can act on the same line in one cycle: an input edge and a clear write, or an input edge and a mask write. The bench provokes the first case by raising an edge line's input in the same cycle as a clear write to that line. It then requires an assert event rather than a lost request. A later clear with no edge must produce the matching deassert. Mask writes are also applied while several requests are pending, and the bench judges the resulting event burst by its strict ascending line order and by `evt_valid` holding while `evt_ready` is low.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  typedef enum logic [3:0] {
    WIN_NONE,
    WIN_ID,
    WIN_MASK,
    WIN_MSGEN,
    WIN_EDGE,
    WIN_CLR,
    WIN_AUTO,
    WIN_ROUTE,
    WIN_VEC,
    WIN_POL
  } win_e;

  // Identification word contents
  localparam logic [31:0] ID_LOW_WORD = 32'h0700_0000;
  localparam logic [15:0] ID_VERSION  = 16'h0001;

  // 8-byte slot numbers (offset / 8) of the word windows
  localparam logic [6:0] SLOT_ID    = 7'd0;
  localparam logic [6:0] SLOT_MASK  = 7'd4;
  localparam logic [6:0] SLOT_MSGEN = 7'd8;
  localparam logic [6:0] SLOT_EDGE  = 7'd12;
  localparam logic [6:0] SLOT_CLR   = 7'd16;
  localparam logic [6:0] SLOT_AUTOA = 7'd24;
  localparam logic [6:0] SLOT_AUTOB = 7'd28;
  localparam logic [6:0] SLOT_POL   = 7'd124;

  // 64-byte block numbers (offset / 64) of the byte windows
  localparam logic [3:0] BLK_ROUTE  = 4'd4;
  localparam logic [3:0] BLK_VEC    = 4'd8;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_route_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output win_e              win,
  output logic              upper,
  output logic [IDX_W-1:0]  idx
);

  logic [6:0] slot;
  logic [3:0] blk;

  assign slot  = addr[9:3];
  assign blk   = addr[9:6];
  assign upper = addr[2];
  assign idx   = addr[IDX_W-1:0];

  always_comb begin
    win = WIN_NONE;
    case (slot)
      SLOT_ID:    win = WIN_ID;
      SLOT_MASK:  win = WIN_MASK;
      SLOT_MSGEN: win = WIN_MSGEN;
      SLOT_EDGE:  win = WIN_EDGE;
      SLOT_CLR:   win = WIN_CLR;
      SLOT_AUTOA: win = WIN_AUTO;
      SLOT_AUTOB: win = WIN_AUTO;
      SLOT_POL:   win = WIN_POL;
      default:    win = WIN_NONE;
    endcase
    if (blk == BLK_ROUTE) win = WIN_ROUTE;
    if (blk == BLK_VEC)   win = WIN_VEC;
  end

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_route_pkg::*;
#(
  parameter int LINES    = 64,
  parameter int VEC_W    = 8,
  parameter int IDX_W    = 6,
  parameter int ID_COUNT = 31
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic                   we,
  input  win_e                   win,
  input  logic                   upper,
  input  logic [IDX_W-1:0]       idx,
  input  logic [31:0]            wdata,
  output logic [LINES-1:0]       mask_q,
  output logic [LINES-1:0]       mask_nx,
  output logic [LINES-1:0]       edge_q,
  output logic [LINES-1:0]       clr_bits,
  output logic [LINES*VEC_W-1:0] vec_flat,
  output logic [31:0]            rdata,
  output logic                   err
);

  localparam int HALF_W = 32;

  logic              wr;
  logic [LINES-1:0]  edge_nx;
  logic [LINES-1:0]  msgen_q;
  logic [LINES-1:0]  msgen_nx;
  logic [VEC_W-1:0]  vec_q [LINES];
  logic              vec_we;
  logic [5:0]        half_lsb;

  assign wr       = req & we;
  assign vec_we   = wr & (win == WIN_VEC);
  assign half_lsb = {upper, 5'd0};

  // Next-state for the 64-bit registers, one half at a time
  always_comb begin
    mask_nx  = mask_q;
    edge_nx  = edge_q;
    msgen_nx = msgen_q;
    clr_bits = '0;
    if (wr) begin
      case (win)
        WIN_MASK:  mask_nx[half_lsb +: HALF_W]  = wdata;
        WIN_EDGE:  edge_nx[half_lsb +: HALF_W]  = wdata;
        WIN_MSGEN: msgen_nx[half_lsb +: HALF_W] = wdata;
        WIN_CLR:   clr_bits[half_lsb +: HALF_W] = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      edge_q  <= '0;
      msgen_q <= '0;
    end else begin
      mask_q  <= mask_nx;
      edge_q  <= edge_nx;
      msgen_q <= msgen_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) vec_q[i] <= '0;
    end else if (vec_we) begin
      vec_q[idx] <= wdata[VEC_W-1:0];
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_vec_flat
    assign vec_flat[g*VEC_W +: VEC_W] = vec_q[g];
  end

  // Same-cycle read data and error flag
  always_comb begin
    rdata = '0;
    err   = 1'b0;
    if (req) begin
      case (win)
        WIN_ID: begin
          err = we;
          if (!we) rdata = upper ? {16'(ID_COUNT), ID_VERSION} : ID_LOW_WORD;
        end
        WIN_MASK:  rdata = mask_q[half_lsb +: HALF_W];
        WIN_MSGEN: rdata = msgen_q[half_lsb +: HALF_W];
        WIN_EDGE:  rdata = edge_q[half_lsb +: HALF_W];
        WIN_CLR:   err = !we;
        WIN_AUTO:  rdata = '0;
        WIN_POL:   rdata = '0;
        WIN_ROUTE: rdata = 32'd1;
        WIN_VEC:   rdata = {{(32-VEC_W){1'b0}}, vec_q[idx]};
        default:   err = 1'b1;
      endcase
    end
  end

  // R2: a low-half mask write keeps the upper half
  assert_other_half_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && win == WIN_MASK && !upper) |=> (mask_q[LINES-1:HALF_W] == $past(mask_q[LINES-1:HALF_W])));

  // R5: an erroring read returns zero
  assert_err_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && err) |-> (rdata == 32'd0));

endmodule

// File: rtl/irq_line_state.sv
module irq_line_state #(
  parameter int LINES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_in,
  input  logic [LINES-1:0] mask_q,
  input  logic [LINES-1:0] mask_nx,
  input  logic [LINES-1:0] edge_q,
  input  logic [LINES-1:0] clr_bits,
  input  logic [LINES-1:0] pop,
  output logic [LINES-1:0] isr_q,
  output logic [LINES-1:0] pend_q
);

  logic [LINES-1:0] in_q, irr_q;
  logic [LINES-1:0] in_nx, irr_nx, isr_nx, pend_nx;

  assign in_nx = irq_in;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic rise, fall, lvl_drop, clr_hit, unmask, remask;
    logic eval_on, eval_off, do_on, do_off;

    assign rise     = irq_in[g] & ~in_q[g];
    assign fall     = ~irq_in[g] & in_q[g];
    assign lvl_drop = fall & ~edge_q[g];
    assign clr_hit  = clr_bits[g] & edge_q[g] & irr_q[g];
    assign unmask   = mask_q[g] & ~mask_nx[g];
    assign remask   = ~mask_q[g] & mask_nx[g];

    // A new rising input wins over a same-cycle clear
    assign irr_nx[g] = (irr_q[g] & ~lvl_drop & ~clr_hit) | rise;

    assign eval_on  = rise | unmask;
    assign eval_off = lvl_drop | clr_hit | remask;
    assign do_on    = eval_on & irr_nx[g] & ~mask_nx[g];
    assign do_off   = eval_off & isr_q[g] & ~irr_nx[g];

    assign isr_nx[g]  = do_on ? 1'b1 : (do_off ? 1'b0 : isr_q[g]);
    assign pend_nx[g] = (pend_q[g] & ~pop[g]) | do_on | do_off;

    // R7: in-service always implies a held request
    assert_isr_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      isr_q[g] |-> irr_q[g]);

    // R7: an edge request survives until a clear write hits it
    assert_edge_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irr_q[g] && edge_q[g] && !clr_bits[g]) |=> irr_q[g]);

    // R12: in-service only starts on an unmasked line
    assert_masked_no_isr_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(isr_q[g]) |-> !mask_q[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      irr_q  <= '0;
      isr_q  <= '0;
      pend_q <= '0;
    end else begin
      in_q   <= in_nx;
      irr_q  <= irr_nx;
      isr_q  <= isr_nx;
      pend_q <= pend_nx;
    end
  end

endmodule

// File: rtl/irq_event_pick.sv
module irq_event_pick #(
  parameter int LINES = 64,
  parameter int VEC_W = 8,
  parameter int IDX_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LINES-1:0]       pend,
  input  logic [LINES-1:0]       isr,
  input  logic [LINES*VEC_W-1:0] vec_flat,
  input  logic                   evt_ready,
  output logic                   evt_valid,
  output logic [VEC_W-1:0]       evt_vec,
  output logic                   evt_level,
  output logic [LINES-1:0]       pop
);

  logic [IDX_W-1:0] sel;
  logic             fire;

  // Lowest pending line wins
  always_comb begin
    sel = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (pend[i]) sel = IDX_W'(i);
    end
  end

  assign evt_valid = |pend;
  assign evt_vec   = vec_flat[sel*VEC_W +: VEC_W];
  assign evt_level = isr[sel];
  assign fire      = evt_valid & evt_ready;

  always_comb begin
    pop      = '0;
    pop[sel] = fire;
  end

  // R10: an offered event stays offered until accepted
  assert_valid_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready) |=> evt_valid);

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int LINES    = 64,
  parameter int VEC_W    = 8,
  parameter int ADDR_W   = 10,
  parameter int ID_COUNT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_in,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic [VEC_W-1:0]  evt_vec,
  output logic              evt_level
);

  localparam int IDX_W = $clog2(LINES);

  logic [1:0]             rst_sync;
  logic                   rst_int_n;
  win_e                   win;
  logic                   upper;
  logic [IDX_W-1:0]       idx;
  logic [LINES-1:0]       mask_q, mask_nx, edge_q, clr_bits;
  logic [LINES-1:0]       isr, pend, pop;
  logic [LINES*VEC_W-1:0] vec_flat;

  // Reset asserts at once and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  irq_bus_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_decode (
    .addr  (bus_addr),
    .win   (win),
    .upper (upper),
    .idx   (idx)
  );

  irq_cfg_regs #(.LINES(LINES), .VEC_W(VEC_W), .IDX_W(IDX_W), .ID_COUNT(ID_COUNT)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .req      (bus_req),
    .we       (bus_we),
    .win      (win),
    .upper    (upper),
    .idx      (idx),
    .wdata    (bus_wdata),
    .mask_q   (mask_q),
    .mask_nx  (mask_nx),
    .edge_q   (edge_q),
    .clr_bits (clr_bits),
    .vec_flat (vec_flat),
    .rdata    (bus_rdata),
    .err      (bus_err)
  );

  irq_line_state #(.LINES(LINES)) u_lines (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .irq_in   (irq_in),
    .mask_q   (mask_q),
    .mask_nx  (mask_nx),
    .edge_q   (edge_q),
    .clr_bits (clr_bits),
    .pop      (pop),
    .isr_q    (isr),
    .pend_q   (pend)
  );

  irq_event_pick #(.LINES(LINES), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_pick (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pend      (pend),
    .isr       (isr),
    .vec_flat  (vec_flat),
    .evt_ready (evt_ready),
    .evt_valid (evt_valid),
    .evt_vec   (evt_vec),
    .evt_level (evt_level),
    .pop       (pop)
  );

endmodule

// File: tb/irq_route_ctrl_tb.sv
`timescale 1ns/100ps
module irq_route_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] irq;
  logic        bus_req, bus_we;
  logic [9:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_err;
  logic        evt_valid, evt_ready, evt_level;
  logic [7:0]  evt_vec;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  irq_route_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_vec(evt_vec), .evt_level(evt_level)
  );

  function automatic logic [7:0] vexp(int i);
    return 8'((i * 29 + 3) & 255);
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, logic [31:0] exp, logic exp_err, string tag);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1;
    chk(bus_rdata == exp && bus_err == exp_err, tag, {bus_err, bus_rdata}, {exp_err, exp});
    bus_req = 1'b0;
  endtask

  task automatic wr_err(logic [9:0] a, string tag);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = 32'hFFFF_FFFF;
    #1;
    chk(bus_err == 1'b1, tag, {63'd0, bus_err}, 64'd1);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic expect_evt(logic [7:0] v, logic lvl, string tag);
    chk(evt_valid && evt_vec == v && evt_level == lvl, tag,
        {55'd0, evt_valid, evt_level, evt_vec}, {55'd0, 1'b1, lvl, v});
    evt_ready = 1'b1;
    tick();
    evt_ready = 1'b0;
  endtask

  task automatic expect_none(string tag);
    chk(!evt_valid, tag, {63'd0, evt_valid}, 64'd0);
  endtask

  task automatic drive_line(int i, logic v);
    irq[i] = v;
    tick();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; irq = '0; bus_req = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0; evt_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    expect_none("R1 no event after reset");
    rd(10'h020, 32'hFFFF_FFFF, 1'b0, "R1 mask low");
    rd(10'h024, 32'hFFFF_FFFF, 1'b0, "R1 mask high");
    rd(10'h060, 32'h0, 1'b0, "R1 edge low");
    rd(10'h064, 32'h0, 1'b0, "R1 edge high");
    rd(10'h040, 32'h0, 1'b0, "R1 msg enable low");
    for (int i = 0; i < 64; i++) rd(10'(10'h200 + i), 32'h0, 1'b0, "R1 vector zero");

    // R3: identification
    rd(10'h000, 32'h0700_0000, 1'b0, "R3 id low");
    rd(10'h004, 32'h001F_0001, 1'b0, "R3 id high");

    // R4: fixed windows, route bytes, vector table sweep
    wr(10'h0C0, 32'hFFFF_FFFF);
    wr(10'h0E4, 32'hFFFF_FFFF);
    wr(10'h3E0, 32'hFFFF_FFFF);
    rd(10'h0C0, 32'h0, 1'b0, "R4 control A");
    rd(10'h0E4, 32'h0, 1'b0, "R4 control B");
    rd(10'h3E0, 32'h0, 1'b0, "R4 polarity");
    for (int i = 0; i < 64; i++) rd(10'(10'h100 + i), 32'h1, 1'b0, "R4 route byte");
    for (int i = 0; i < 64; i++) wr(10'(10'h200 + i), 32'hABCD_EF00 | 32'(vexp(i)));
    for (int i = 0; i < 64; i++) rd(10'(10'h200 + i), 32'(vexp(i)), 1'b0, "R4 vector readback");

    // R5: errors
    rd(10'h380, 32'h0, 1'b1, "R5 unknown offset");
    rd(10'h010, 32'h0, 1'b1, "R5 gap offset");
    rd(10'h080, 32'h0, 1'b1, "R5 clear read");
    wr_err(10'h000, "R5 id write");
    rd(10'h024, 32'hFFFF_FFFF, 1'b0, "R5 valid offset no error");

    // R2: half-word access
    wr(10'h020, 32'h0000_00F0);
    rd(10'h020, 32'h0000_00F0, 1'b0, "R2 mask low written");
    rd(10'h024, 32'hFFFF_FFFF, 1'b0, "R2 mask high kept");
    wr(10'h024, 32'h1234_5678);
    rd(10'h020, 32'h0000_00F0, 1'b0, "R2 mask low kept");
    rd(10'h024, 32'h1234_5678, 1'b0, "R2 mask high written");
    wr(10'h044, 32'hA5A5_0001);
    rd(10'h044, 32'hA5A5_0001, 1'b0, "R2 msg enable high");
    rd(10'h040, 32'h0, 1'b0, "R2 msg enable low kept");
    wr(10'h064, 32'h8000_0000);
    rd(10'h064, 32'h8000_0000, 1'b0, "R2 edge high");
    rd(10'h060, 32'h0, 1'b0, "R2 edge low kept");
    wr(10'h064, 32'h0);

    // Unmask all lines; nothing is requested, so no events
    wr(10'h020, 32'h0);
    wr(10'h024, 32'h0);
    expect_none("R9 unmask without request");

    // R6: level sweep over all lines
    for (int i = 0; i < 64; i++) begin
      drive_line(i, 1'b1);
      expect_evt(vexp(i), 1'b1, "R6 level assert");
      drive_line(i, 1'b0);
      expect_evt(vexp(i), 1'b0, "R6 level deassert");
    end
    expect_none("R6 quiet after sweep");

    // R7 / R8: edge lines
    wr(10'h060, 32'hFFFF_FFFF);
    wr(10'h064, 32'hFFFF_FEFF);  // line 40 stays level
    drive_line(5, 1'b1);
    expect_evt(vexp(5), 1'b1, "R7 edge assert");
    drive_line(5, 1'b0);
    tick();
    expect_none("R7 edge fall ignored");
    wr(10'h080, 32'h0000_0040);  // line 6, no request
    expect_none("R8 clear without request");
    wr(10'h080, 32'h0000_0020);
    expect_evt(vexp(5), 1'b0, "R8 clear deasserts");
    expect_none("R8 single deassert");
    drive_line(33, 1'b1);
    expect_evt(vexp(33), 1'b1, "R8 upper edge assert");
    wr(10'h084, 32'h0000_0002);
    expect_evt(vexp(33), 1'b0, "R8 upper clear");
    drive_line(33, 1'b0);
    drive_line(40, 1'b1);
    expect_evt(vexp(40), 1'b1, "R8 level line assert");
    wr(10'h084, 32'h0000_0100);
    expect_none("R8 clear ignores level line");
    drive_line(40, 1'b0);
    expect_evt(vexp(40), 1'b0, "R8 level line deassert");

    // R8: rising input in the same cycle as a clear
    drive_line(7, 1'b1);
    expect_evt(vexp(7), 1'b1, "R8 first edge");
    drive_line(7, 1'b0);
    irq[7] = 1'b1;
    wr(10'h080, 32'h0000_0080);
    expect_evt(vexp(7), 1'b1, "R8 edge wins over clear");
    expect_none("R8 no extra event");
    wr(10'h080, 32'h0000_0080);
    expect_evt(vexp(7), 1'b0, "R8 later clear");
    drive_line(7, 1'b0);
    expect_none("R8 quiet");
    wr(10'h060, 32'h0);
    wr(10'h064, 32'h0);

    // R12 / R9: masks
    wr(10'h020, 32'h0000_0400);
    drive_line(10, 1'b1);
    tick();
    expect_none("R12 masked rise silent");
    wr(10'h020, 32'h0);
    expect_evt(vexp(10), 1'b1, "R9 unmask replays assert");
    drive_line(10, 1'b0);
    expect_evt(vexp(10), 1'b0, "R9 deassert after unmask");
    drive_line(11, 1'b1);
    expect_evt(vexp(11), 1'b1, "R9 line 11 assert");
    wr(10'h020, 32'h0000_0800);
    expect_none("R9 masking does not retract");
    drive_line(11, 1'b0);
    expect_evt(vexp(11), 1'b0, "R9 deassert while masked");
    wr(10'h020, 32'h0);
    expect_none("R9 unmask without request");

    // R10: ordering after a mask change
    wr(10'h020, 32'hFFFF_FFFF);
    irq[20] = 1'b1; irq[3] = 1'b1; irq[9] = 1'b1;
    tick();
    expect_none("R12 masked burst silent");
    wr(10'h020, 32'h0);
    for (int k = 0; k < 3; k++) begin
      chk(evt_valid && evt_vec == vexp(3), "R10 held while not ready",
          {55'd0, evt_valid, 8'(evt_vec)}, {55'd0, 1'b1, vexp(3)});
      tick();
    end
    expect_evt(vexp(3), 1'b1, "R10 order first");
    expect_evt(vexp(9), 1'b1, "R10 order second");
    expect_evt(vexp(20), 1'b1, "R10 order third");
    irq[3] = 1'b0; irq[9] = 1'b0; irq[20] = 1'b0;
    tick();
    expect_evt(vexp(3), 1'b0, "R10 deassert first");
    expect_evt(vexp(9), 1'b0, "R10 deassert second");
    expect_evt(vexp(20), 1'b0, "R10 deassert third");
    expect_none("R10 drained");

    // R11: coalescing of an undelivered event
    drive_line(25, 1'b1);
    drive_line(25, 1'b0);
    expect_evt(vexp(25), 1'b0, "R11 current level carried");
    expect_none("R11 single event");

    finish_run();
  end

endmodule